// File: doc/BRIEF.md
# Execute Redirect Squash Arbiter

This block watches the instructions that leave the execute lanes in one cycle. For each hardware thread it sends at most one squash message to the commit stage. Three causes can start a squash: a branch whose prediction was wrong, a memory-order violation flagged by the load/store queue, and a load that the load/store queue reports as blocked. Each cause builds its message in a different way. The redirect target, the mispredict PC, the branch-taken flag and the flag that says whether the squashing instruction is itself discarded all depend on the cause.

Lanes are presented oldest-first, so lane 0 holds the oldest instruction. A per-thread claim is formed fresh every cycle, and the lowest-numbered qualifying lane of a thread wins that thread's message. Lanes that arrive already squashed pass through as executed. They never start a redirect. A load-blocked squash also raises a handled pulse toward the load/store queue, so the same blocked load does not squash twice. Two counters record winning mispredicts, split by whether the branch was predicted taken.

Top module: `exec_squash_arb`

## Requirements
- R1: While rst_ni is low, every output is 0: squash valid, message fields, handled pulses and both counters.
- R2: An event presented in cycle N appears on the outputs after the next rising edge and lasts one cycle only. With no event in cycle N+1, squash valid returns to 0.
- R3: Within a thread, only the lowest-indexed lane that carries a qualifying event produces the message. Events in higher lanes of the same thread and cycle have no effect.
- R4: Within one lane, mispredict takes precedence over memory-order violation, and memory-order violation takes precedence over load blocked.
- R5: A mispredict message carries the lane's sequence number, redirect target = next PC, mispredict PC = PC, mispredict flag = 1 and include flag = 0.
- R6: On a mispredict, branch-taken is 1 exactly when next PC differs from PC + INST_BYTES (default 4). For every other cause it is 0.
- R7: A memory-order message carries the sequence number, redirect target = next PC, mispredict PC = 0, mispredict flag = 0, taken = 0 and include flag = 0.
- R8: A load-blocked message carries the sequence number, redirect target = the lane's own PC and include flag = 1. The thread's handled pulse is 1 in the same cycle as that message and 0 at all other times.
- R9: A lane with valid = 0 or squashed = 1 never produces a message. A later live event of the same thread can still win.
- R10: Threads are arbitrated independently, so every thread may receive its own message in the same cycle.
- R11: Each winning mispredict adds 1 to the predicted-taken counter when its predicted-taken input is 1, and to the predicted-not-taken counter otherwise. Losing mispredicts and other causes are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_valid_i | input | NUM_LANES | Lane holds an instruction |
| lane_squashed_i | input | NUM_LANES | Instruction was already squashed |
| lane_tid_i | input | NUM_LANES x TID_W | Thread of the instruction |
| lane_seq_i | input | NUM_LANES x SEQ_W | Sequence number |
| lane_pc_i | input | NUM_LANES x PC_W | Instruction PC |
| lane_npc_i | input | NUM_LANES x PC_W | Resolved next PC |
| lane_mispred_i | input | NUM_LANES | Branch resolved against its prediction |
| lane_pred_taken_i | input | NUM_LANES | Branch had been predicted taken |
| lane_memviol_i | input | NUM_LANES | Memory-order violation on this instruction |
| lane_ldblk_i | input | NUM_LANES | Load is blocked in memory |
| sq_valid_o | output | NUM_THREADS | Squash message valid per thread |
| sq_seq_o | output | NUM_THREADS x SEQ_W | Sequence number of the squashing instruction |
| sq_target_o | output | NUM_THREADS x PC_W | Redirect PC |
| sq_mis_pc_o | output | NUM_THREADS x PC_W | PC of the mispredicted branch |
| sq_mispred_o | output | NUM_THREADS | Message is a branch mispredict |
| sq_taken_o | output | NUM_THREADS | Mispredicted branch was actually taken |
| sq_incl_o | output | NUM_THREADS | Squash also discards the squashing instruction |
| ld_handled_o | output | NUM_THREADS | Blocked load has been handled |
| mp_ptk_cnt_o | output | CNT_W | Mispredicts that had been predicted taken |
| mp_pnt_cnt_o | output | CNT_W | Mispredicts that had been predicted not taken |

## Verification
A table of lane patterns is walked first, with one pattern per cycle. Single-cause patterns fix each message format, including taken and not-taken resolutions. Lanes that raise several causes at once separate the cause order from the lane order. Two events of the same thread in different lanes show whether the oldest one wins. A dead or squashed event placed ahead of a live one shows that filtering happens before arbitration. Mixed-thread patterns show that the two threads do not block each other. An idle cycle checks that the message lasts one cycle, the accumulated counts check the split by prediction direction, and a reset in mid-run checks that everything clears.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_MISP   = 2'd1,
    CAUSE_MEMORD = 2'd2,
    CAUSE_LDBLK  = 2'd3
  } cause_e;
endpackage

// File: rtl/sqa_lane_decode.sv
module sqa_lane_decode
  import sqa_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic            valid_i,
  input  logic            squashed_i,
  input  logic            mispred_i,
  input  logic            memviol_i,
  input  logic            ldblk_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  output cause_e          cause_o,
  output logic [PC_W-1:0] target_o,
  output logic [PC_W-1:0] mis_pc_o,
  output logic            taken_o
);
  logic live;
  logic [PC_W-1:0] fall_pc;

  assign live    = valid_i & ~squashed_i;
  assign fall_pc = pc_i + PC_W'(INST_BYTES);

  always_comb begin
    cause_o = CAUSE_NONE;
    if (live) begin
      if (mispred_i)      cause_o = CAUSE_MISP;
      else if (memviol_i) cause_o = CAUSE_MEMORD;
      else if (ldblk_i)   cause_o = CAUSE_LDBLK;
    end
  end

  assign target_o = (cause_o == CAUSE_LDBLK) ? pc_i : npc_i;
  assign mis_pc_o = (cause_o == CAUSE_MISP) ? pc_i : '0;
  assign taken_o  = (cause_o == CAUSE_MISP) && (npc_i != fall_pc);

  always_comb begin
    // R4
    if (cause_o == CAUSE_LDBLK) begin
      ldblk_prio_chk: assert (!mispred_i && !memviol_i);
    end
    // R9
    if (!live) begin
      dead_lane_chk: assert (cause_o == CAUSE_NONE);
    end
  end
endmodule

// File: rtl/sqa_thread_pick.sv
module sqa_thread_pick
  import sqa_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int TID_W     = 1,
  parameter int THREAD_ID = 0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  cause_e [NUM_LANES-1:0]          cause_i,
  input  logic   [NUM_LANES-1:0][TID_W-1:0] tid_i,
  output logic   [NUM_LANES-1:0]          grant_o,
  output logic                            hit_o
);
  logic [NUM_LANES-1:0] req;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_req
    assign req[l] = (cause_i[l] != CAUSE_NONE) && (tid_i[l] == TID_W'(THREAD_ID));
  end

  // oldest lane first
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (req[l] && !found) begin
        grant_o[l] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign hit_o = |req;

  // R3
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req) == '0));

  // R3
  grant_when_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (grant_o != '0));
endmodule

// File: rtl/sqa_stat_cnt.sv
module sqa_stat_cnt #(
  parameter int CNT_W = 16,
  parameter int NUM_INC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INC-1:0] inc_i,
  output logic [CNT_W-1:0]   cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + CNT_W'($countones(inc_i));
  end

  // R11
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |=> $stable(cnt_o));
endmodule

// File: rtl/exec_squash_arb.sv
module exec_squash_arb
  import sqa_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int INST_BYTES  = 4,
  parameter int CNT_W       = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [NUM_LANES-1:0]                    lane_valid_i,
  input  logic [NUM_LANES-1:0]                    lane_squashed_i,
  input  logic [NUM_LANES-1:0][TID_W-1:0]         lane_tid_i,
  input  logic [NUM_LANES-1:0][SEQ_W-1:0]         lane_seq_i,
  input  logic [NUM_LANES-1:0][PC_W-1:0]          lane_pc_i,
  input  logic [NUM_LANES-1:0][PC_W-1:0]          lane_npc_i,
  input  logic [NUM_LANES-1:0]                    lane_mispred_i,
  input  logic [NUM_LANES-1:0]                    lane_pred_taken_i,
  input  logic [NUM_LANES-1:0]                    lane_memviol_i,
  input  logic [NUM_LANES-1:0]                    lane_ldblk_i,
  output logic [NUM_THREADS-1:0]                  sq_valid_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]       sq_seq_o,
  output logic [NUM_THREADS-1:0][PC_W-1:0]        sq_target_o,
  output logic [NUM_THREADS-1:0][PC_W-1:0]        sq_mis_pc_o,
  output logic [NUM_THREADS-1:0]                  sq_mispred_o,
  output logic [NUM_THREADS-1:0]                  sq_taken_o,
  output logic [NUM_THREADS-1:0]                  sq_incl_o,
  output logic [NUM_THREADS-1:0]                  ld_handled_o,
  output logic [CNT_W-1:0]                        mp_ptk_cnt_o,
  output logic [CNT_W-1:0]                        mp_pnt_cnt_o
);
  cause_e [NUM_LANES-1:0]            l_cause;
  logic   [NUM_LANES-1:0][PC_W-1:0]  l_target;
  logic   [NUM_LANES-1:0][PC_W-1:0]  l_mis_pc;
  logic   [NUM_LANES-1:0]            l_taken;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    sqa_lane_decode #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_dec (
      .valid_i   (lane_valid_i[l]),
      .squashed_i(lane_squashed_i[l]),
      .mispred_i (lane_mispred_i[l]),
      .memviol_i (lane_memviol_i[l]),
      .ldblk_i   (lane_ldblk_i[l]),
      .pc_i      (lane_pc_i[l]),
      .npc_i     (lane_npc_i[l]),
      .cause_o   (l_cause[l]),
      .target_o  (l_target[l]),
      .mis_pc_o  (l_mis_pc[l]),
      .taken_o   (l_taken[l])
    );
  end

  logic [NUM_THREADS-1:0][NUM_LANES-1:0] grant;
  logic [NUM_THREADS-1:0]                hit;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    sqa_thread_pick #(.NUM_LANES(NUM_LANES), .TID_W(TID_W), .THREAD_ID(t)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cause_i(l_cause),
      .tid_i  (lane_tid_i),
      .grant_o(grant[t]),
      .hit_o  (hit[t])
    );
  end

  // winner mux, fresh every cycle
  logic [NUM_THREADS-1:0][SEQ_W-1:0] p_seq;
  logic [NUM_THREADS-1:0][PC_W-1:0]  p_target, p_mis_pc;
  logic [NUM_THREADS-1:0]            p_misp, p_taken, p_incl, p_ptk;

  always_comb begin
    p_seq = '0; p_target = '0; p_mis_pc = '0;
    p_misp = '0; p_taken = '0; p_incl = '0; p_ptk = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (grant[t][l]) begin
          p_seq[t]    = lane_seq_i[l];
          p_target[t] = l_target[l];
          p_mis_pc[t] = l_mis_pc[l];
          p_misp[t]   = (l_cause[l] == CAUSE_MISP);
          p_taken[t]  = l_taken[l];
          p_incl[t]   = (l_cause[l] == CAUSE_LDBLK);
          p_ptk[t]    = lane_pred_taken_i[l];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_valid_o   <= '0;
      sq_seq_o     <= '0;
      sq_target_o  <= '0;
      sq_mis_pc_o  <= '0;
      sq_mispred_o <= '0;
      sq_taken_o   <= '0;
      sq_incl_o    <= '0;
      ld_handled_o <= '0;
    end else begin
      sq_valid_o   <= hit;
      sq_seq_o     <= p_seq;
      sq_target_o  <= p_target;
      sq_mis_pc_o  <= p_mis_pc;
      sq_mispred_o <= p_misp;
      sq_taken_o   <= p_taken;
      sq_incl_o    <= p_incl;
      ld_handled_o <= hit & p_incl;
    end
  end

  logic [NUM_THREADS-1:0] ptk_inc, pnt_inc;
  assign ptk_inc = hit & p_misp & p_ptk;
  assign pnt_inc = hit & p_misp & ~p_ptk;

  sqa_stat_cnt #(.CNT_W(CNT_W), .NUM_INC(NUM_THREADS)) u_ptk_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ptk_inc), .cnt_o(mp_ptk_cnt_o));
  sqa_stat_cnt #(.CNT_W(CNT_W), .NUM_INC(NUM_THREADS)) u_pnt_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pnt_inc), .cnt_o(mp_pnt_cnt_o));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R8
    handled_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_handled_o[t] |-> (sq_valid_o[t] && sq_incl_o[t] && !sq_mispred_o[t]));
    // R6
    taken_misp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sq_taken_o[t] |-> sq_mispred_o[t]);
    // R7
    mis_pc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sq_valid_o[t] && !sq_mispred_o[t]) |-> (sq_mis_pc_o[t] == '0));
    // R9
    live_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sq_valid_o[t] |-> $past((lane_valid_i & ~lane_squashed_i) != '0));
  end
endmodule

// File: tb/sim_exec_squash_arb.sv
module sim_exec_squash_arb;
  localparam int L = 4;
  localparam int T = 2;
  localparam int SEQ_W = 16;
  localparam int PC_W = 32;
  localparam int CNT_W = 16;
  localparam int NV = 12;

  // lane code: [7]valid [6]squashed [5]tid [4]misp [3]memviol [2]ldblk [1]pred_taken [0]jump
  typedef struct packed {
    logic [L-1:0][7:0] lanes;
    logic [T-1:0]      ev;
    logic [T-1:0][1:0] win;
    logic [T-1:0][1:0] cause; // 1 misp, 2 memorder, 3 ldblk
  } vec_t;

  function automatic logic [7:0] lc(input bit v, s, tid, m, mo, lb, pt, j);
    return {v, s, tid, m, mo, lb, pt, j};
  endfunction

  function automatic vec_t mkv(input logic [7:0] l0, l1, l2, l3,
                               input bit e0, input int w0, c0,
                               input bit e1, input int w1, c1);
    vec_t v;
    v.lanes = {l3, l2, l1, l0};
    v.ev    = {e1, e0};
    v.win   = {2'(w1), 2'(w0)};
    v.cause = {2'(c1), 2'(c0)};
    return v;
  endfunction

  localparam logic [7:0] IDL = 8'h00;
  localparam vec_t VEC [NV] = '{
    mkv(IDL, IDL, IDL, IDL, 0,0,0, 0,0,0),
    mkv(lc(1,0,0,1,0,0,0,1), IDL, IDL, IDL, 1,0,1, 0,0,0),
    mkv(IDL, lc(1,0,1,1,0,0,1,0), IDL, IDL, 0,0,0, 1,1,1),
    mkv(lc(1,0,0,0,1,0,0,0), IDL, lc(1,0,0,1,0,0,1,1), IDL, 1,0,2, 0,0,0),
    mkv(lc(1,0,0,1,1,1,0,0), IDL, IDL, IDL, 1,0,1, 0,0,0),
    mkv(IDL, lc(1,0,1,0,1,1,0,0), IDL, IDL, 0,0,0, 1,1,2),
    mkv(IDL, IDL, IDL, lc(1,0,0,0,0,1,0,0), 1,3,3, 0,0,0),
    mkv(lc(1,1,0,1,0,0,1,1), lc(1,0,0,0,0,1,0,0), IDL, IDL, 1,1,3, 0,0,0),
    mkv(lc(0,0,0,1,0,0,0,1), IDL, lc(1,0,0,0,1,0,0,0), IDL, 1,2,2, 0,0,0),
    mkv(lc(1,0,1,0,0,1,0,0), lc(1,0,0,1,0,0,1,1), lc(1,0,1,1,0,0,0,1),
        lc(1,0,0,0,1,0,0,0), 1,1,1, 1,0,3),
    mkv(lc(1,1,0,0,0,1,0,0), IDL, IDL, IDL, 0,0,0, 0,0,0),
    mkv(IDL, IDL, lc(1,0,1,1,0,0,0,0), IDL, 0,0,0, 1,2,1)
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [L-1:0]             lane_valid, lane_sqd, lane_misp, lane_ptk, lane_mem, lane_ldb;
  logic [L-1:0][0:0]        lane_tid;
  logic [L-1:0][SEQ_W-1:0]  lane_seq;
  logic [L-1:0][PC_W-1:0]   lane_pc, lane_npc;
  logic [T-1:0]             sq_valid, sq_misp, sq_taken, sq_incl, ld_handled;
  logic [T-1:0][SEQ_W-1:0]  sq_seq;
  logic [T-1:0][PC_W-1:0]   sq_target, sq_mis_pc;
  logic [CNT_W-1:0]         ptk_cnt, pnt_cnt;

  exec_squash_arb u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lane_valid_i(lane_valid), .lane_squashed_i(lane_sqd), .lane_tid_i(lane_tid),
    .lane_seq_i(lane_seq), .lane_pc_i(lane_pc), .lane_npc_i(lane_npc),
    .lane_mispred_i(lane_misp), .lane_pred_taken_i(lane_ptk),
    .lane_memviol_i(lane_mem), .lane_ldblk_i(lane_ldb),
    .sq_valid_o(sq_valid), .sq_seq_o(sq_seq), .sq_target_o(sq_target),
    .sq_mis_pc_o(sq_mis_pc), .sq_mispred_o(sq_misp), .sq_taken_o(sq_taken),
    .sq_incl_o(sq_incl), .ld_handled_o(ld_handled),
    .mp_ptk_cnt_o(ptk_cnt), .mp_pnt_cnt_o(pnt_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input int vi, input int l);
    return PC_W'(32'h1000 + vi * 256 + l * 16);
  endfunction

  task automatic drive(input int vi);
    for (int l = 0; l < L; l++) begin
      logic [7:0] c;
      c = VEC[vi].lanes[l];
      lane_valid[l] = c[7];
      lane_sqd[l]   = c[6];
      lane_tid[l]   = c[5];
      lane_misp[l]  = c[4];
      lane_mem[l]   = c[3];
      lane_ldb[l]   = c[2];
      lane_ptk[l]   = c[1];
      lane_pc[l]    = pc_of(vi, l);
      lane_npc[l]   = c[0] ? pc_of(vi, l) + 64 : pc_of(vi, l) + 4;
      lane_seq[l]   = SEQ_W'(vi * 8 + l);
    end
  endtask

  task automatic drive_idle();
    lane_valid = '0; lane_sqd = '0; lane_tid = '0; lane_misp = '0;
    lane_mem = '0; lane_ldb = '0; lane_ptk = '0;
    lane_pc = '0; lane_npc = '0; lane_seq = '0;
  endtask

  task automatic check_idle(input string req);
    check(req, "sq_valid", 32'(sq_valid), 0);
    check(req, "ld_handled", 32'(ld_handled), 0);
  endtask

  int exp_ptk = 0;
  int exp_pnt = 0;

  initial begin
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_idle("R1");
    check("R1", "sq_incl", 32'(sq_incl), 0);
    check("R1", "ptk_cnt", 32'(ptk_cnt), 0);
    check("R1", "pnt_cnt", 32'(pnt_cnt), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int vi = 0; vi < NV; vi++) begin
      drive(vi);
      @(negedge clk);
      for (int t = 0; t < T; t++) begin
        int w, c;
        logic [7:0] lcode;
        logic [PC_W-1:0] pc, npc;
        w = int'(VEC[vi].win[t]);
        c = int'(VEC[vi].cause[t]);
        lcode = VEC[vi].lanes[w];
        pc  = pc_of(vi, w);
        npc = lcode[0] ? pc + 64 : pc + 4;
        // R3 R9 R10: which thread gets a message
        check("R3", $sformatf("v%0d t%0d valid", vi, t), 32'(sq_valid[t]), 32'(VEC[vi].ev[t]));
        if (VEC[vi].ev[t]) begin
          check("R3", $sformatf("v%0d t%0d seq", vi, t), 32'(sq_seq[t]), 32'(vi * 8 + w));
          if (c == 1) begin
            // R5 R6
            check("R5", $sformatf("v%0d t%0d target", vi, t), sq_target[t], npc);
            check("R5", $sformatf("v%0d t%0d mis_pc", vi, t), sq_mis_pc[t], pc);
            check("R5", $sformatf("v%0d t%0d misp", vi, t), 32'(sq_misp[t]), 1);
            check("R6", $sformatf("v%0d t%0d taken", vi, t), 32'(sq_taken[t]), 32'(lcode[0]));
            check("R5", $sformatf("v%0d t%0d incl", vi, t), 32'(sq_incl[t]), 0);
            if (lcode[1]) exp_ptk++; else exp_pnt++;
          end else if (c == 2) begin
            // R4 R7
            check("R7", $sformatf("v%0d t%0d target", vi, t), sq_target[t], npc);
            check("R7", $sformatf("v%0d t%0d mis_pc", vi, t), sq_mis_pc[t], 0);
            check("R4", $sformatf("v%0d t%0d misp", vi, t), 32'(sq_misp[t]), 0);
            check("R7", $sformatf("v%0d t%0d taken", vi, t), 32'(sq_taken[t]), 0);
            check("R7", $sformatf("v%0d t%0d incl", vi, t), 32'(sq_incl[t]), 0);
          end else begin
            // R8
            check("R8", $sformatf("v%0d t%0d target", vi, t), sq_target[t], pc);
            check("R8", $sformatf("v%0d t%0d incl", vi, t), 32'(sq_incl[t]), 1);
            check("R8", $sformatf("v%0d t%0d misp", vi, t), 32'(sq_misp[t]), 0);
          end
          check("R8", $sformatf("v%0d t%0d handled", vi, t), 32'(ld_handled[t]), 32'(c == 3));
        end else begin
          check("R9", $sformatf("v%0d t%0d handled", vi, t), 32'(ld_handled[t]), 0);
        end
      end
    end

    // R2: message lasts one cycle
    drive_idle();
    @(negedge clk);
    check_idle("R2");

    // R11: counter split by prediction direction
    check("R11", "ptk_cnt", 32'(ptk_cnt), 32'(exp_ptk));
    check("R11", "pnt_cnt", 32'(pnt_cnt), 32'(exp_pnt));
    check("R11", "ptk total", 32'(exp_ptk), 2);
    check("R11", "pnt total", 32'(exp_pnt), 3);

    // R1: reset in mid-run clears everything
    drive(1);
    @(negedge clk);
    check("R2", "re-event valid", 32'(sq_valid), 1);
    rst_ni = 1'b0;
    #1;
    check_idle("R1");
    check("R1", "ptk_cnt after reset", 32'(ptk_cnt), 0);
    check("R1", "pnt_cnt after reset", 32'(pnt_cnt), 0);
    drive_idle();
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule